// File: doc/BRIEF.md
# Boot-Processor Watchdog with Failover

This block guards the early start-up of a multiprocessor board. Whenever the system leaves a full reset, a countdown begins without any firmware action. Firmware running on the current bootstrap processor is expected to stop it. If that does not happen in time, the block drives a system reset pulse and hands the bootstrap role to the next processor. It then restarts the countdown. A processor that misses its deadline is only recorded in a failure mask; it is never switched off. When every processor has missed, the block stops issuing resets and raises a beep-code request for an external tone generator.

A small write-only command port serves several purposes. It loads the start-up timeout, disarms the countdown, and clears the sticky status flags. It can also rearm the countdown as an operating-system-load watchdog, with a timeout of 5, 10, 15 or 20 minutes chosen by a 2-bit code. A free-running prescaler turns the core clock into a tick, nominally 1 ms, so minute-scale timeouts fit the counter.

Top module: `boot_failover_wdog`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the outputs hold these values: `bsp_sel` = bit 0 set only, `fail_mask` = 0, `sys_rst_out` = 0, `beep_req` = 0, `os_mode` = 0, all three status flags 0, and `wd_running` = 1.
- R2: The start-up countdown runs on its own after `rst_n` rises. With a timeout of N ticks of PRESC clocks each, `sys_rst_out` rises between (N-1)*PRESC and N*PRESC+3 cycles later. The timeout after `rst_n` is DEF_TIMEOUT.
- R3: A write with `reg_addr` = 1 (disarm) while counting drops `wd_running` on the next cycle. After that, no reset pulse follows and `bsp_sel` and `fail_mask` keep their values.
- R4: On a start-up expiry, the bit of the current bootstrap processor is added to `fail_mask` and `sts_boot_fail` is set. `sys_rst_out` then stays high for exactly RST_CYC cycles. Before it falls, `bsp_sel` has moved from bit i to bit i+1.
- R5: After each watchdog reset pulse, the start-up countdown restarts with the loaded timeout. Each further failing processor produces another pulse and rotation.
- R6: When the expiry of the last untried processor leaves `fail_mask` all ones, no reset pulse follows. Instead `beep_req`, `sts_all_fail` and `wd_running` = 0 hold until `rst_n`.
- R7: `soft_rst` has no effect on the countdown timing, the rotation, the failure mask or the disarmed state.
- R8: A write with `reg_addr` = 0 stores `reg_wdata` as the start-up timeout in ticks. Every countdown that starts after the write uses this value.
- R9: A write with `reg_addr` = 2 arms the operating-system-load countdown, with `os_mode` = 1, for (code+1)*5*TICKS_PER_MIN ticks, where the code is `reg_wdata[1:0]`. On its expiry the block sets `sts_os_fail`, pulses `sys_rst_out` for RST_CYC cycles, and leaves `bsp_sel` and `fail_mask` untouched. The block then restarts the start-up countdown with `os_mode` = 0.
- R10: Lowering `rst_n` restarts the rotation at processor 0. It also clears `fail_mask` and `beep_req`, including out of the alarm state.
- R11: The status flags are sticky across watchdog resets. A write with `reg_addr` = 3 clears `sts_boot_fail`, `sts_os_fail` and `sts_all_fail` for `reg_wdata` bits 0, 1 and 2 set. `fail_mask` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on / full system reset, active low |
| soft_rst | input | 1 | Soft reset indication, ignored by the watchdog |
| reg_wr | input | 1 | Command write strobe |
| reg_addr | input | 2 | Command select: 0 load, 1 disarm, 2 OS arm, 3 clear status |
| reg_wdata | input | CNT_W | Command data |
| sys_rst_out | output | 1 | System reset request pulse |
| bsp_sel | output | NPROC | One-hot bootstrap processor select |
| fail_mask | output | NPROC | Processors that missed their deadline |
| beep_req | output | 1 | Beep-code request, all processors failed |
| wd_running | output | 1 | Countdown active |
| os_mode | output | 1 | Countdown is the OS-load watchdog |
| sts_boot_fail | output | 1 | Sticky: a start-up expiry occurred |
| sts_os_fail | output | 1 | Sticky: an OS-load expiry occurred |
| sts_all_fail | output | 1 | Sticky: every processor failed |

## Verification
The hardest situation to reach is the alarm state, which needs every processor to time out in turn with rotation and mask growth at each step. The bench sweeps k = 0 to NPROC: it lets the first k processors expire, disarms on processor k when k is smaller than NPROC, and checks mask, select and pulse length at every step. The OS-load timeout is swept over all four codes, with a shortened prescaler and minute length so that the longest code finishes in a few hundred cycles.

// File: rtl/bfw_pkg.sv
`timescale 1ns/1ps
package bfw_pkg;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_IDLE  = 2'd1,
    ST_RESET = 2'd2,
    ST_ALARM = 2'd3
  } wd_state_e;

  localparam logic [1:0] CMD_LOAD  = 2'd0;
  localparam logic [1:0] CMD_STOP  = 2'd1;
  localparam logic [1:0] CMD_OSARM = 2'd2;
  localparam logic [1:0] CMD_CLEAR = 2'd3;

  // OS-load timeout in ticks: 5, 10, 15 or 20 minutes
  function automatic int unsigned os_ticks(input logic [1:0] code,
                                           input int unsigned per_min);
    return (32'(code) + 32'd1) * 32'd5 * per_min;
  endfunction

endpackage

// File: rtl/bfw_tick_gen.sv
`timescale 1ns/1ps
module bfw_tick_gen #(
  parameter int PRESC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

  logic [PW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + PW'(1);
  end
endmodule

// File: rtl/bfw_countdown.sv
`timescale 1ns/1ps
module bfw_countdown #(
  parameter int CNT_W = 21,
  parameter int INIT  = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // a value of 0 or 1 both expire on the first tick
  assign expire = run && tick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= CNT_W'(INIT);
    else if (load)                    cnt_q <= load_val;
    else if (run && tick && !expire)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/bfw_bsp_rotator.sv
`timescale 1ns/1ps
module bfw_bsp_rotator #(
  parameter int NPROC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [NPROC-1:0] bsp_sel,
  output logic [NPROC-1:0] fail_mask,
  output logic             last_fail
);
  logic [NPROC-1:0] next_sel;

  genvar gi;
  generate
    for (gi = 0; gi < NPROC; gi++) begin : g_rot
      assign next_sel[gi] = bsp_sel[(gi + NPROC - 1) % NPROC];
    end
  endgenerate

  // the failure now being recorded would complete the mask
  assign last_fail = &(fail_mask | bsp_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsp_sel   <= NPROC'(1);
      fail_mask <= '0;
    end else if (advance) begin
      fail_mask <= fail_mask | bsp_sel;
      if (!last_fail) bsp_sel <= next_sel;
    end
  end
endmodule

// File: rtl/boot_failover_wdog.sv
`timescale 1ns/1ps
module boot_failover_wdog
  import bfw_pkg::*;
#(
  parameter int NPROC         = 4,
  parameter int CNT_W         = 21,
  parameter int PRESC         = 50000,
  parameter int TICKS_PER_MIN = 60000,
  parameter int DEF_TIMEOUT   = 2000,
  parameter int RST_CYC       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic             sys_rst_out,
  output logic [NPROC-1:0] bsp_sel,
  output logic [NPROC-1:0] fail_mask,
  output logic             beep_req,
  output logic             wd_running,
  output logic             os_mode,
  output logic             sts_boot_fail,
  output logic             sts_os_fail,
  output logic             sts_all_fail
);
  localparam int RC_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  wd_state_e        st_q, st_d;
  logic             mode_q, mode_d;
  logic [CNT_W-1:0] boot_to_q;
  logic [RC_W-1:0]  rc_q;

  // named internal events
  logic tick, cd_expire, boot_expire, os_expire, last_fail;
  logic load_cmd, disarm_cmd, arm_cmd, clear_cmd, arm_ok;
  logic enter_alarm, enter_reset, leave_reset, cd_load;
  logic [CNT_W-1:0] cd_val, os_val;

  assign load_cmd   = reg_wr && (reg_addr == CMD_LOAD);
  assign disarm_cmd = reg_wr && (reg_addr == CMD_STOP);
  assign arm_cmd    = reg_wr && (reg_addr == CMD_OSARM);
  assign clear_cmd  = reg_wr && (reg_addr == CMD_CLEAR);

  assign os_val      = CNT_W'(os_ticks(reg_wdata[1:0], TICKS_PER_MIN));
  assign boot_expire = cd_expire && !mode_q;
  assign os_expire   = cd_expire && mode_q;
  assign enter_alarm = boot_expire && last_fail;
  assign enter_reset = cd_expire && !enter_alarm;
  assign leave_reset = (st_q == ST_RESET) && (rc_q == '0);
  assign arm_ok      = arm_cmd && !cd_expire &&
                       ((st_q == ST_COUNT) || (st_q == ST_IDLE));
  assign cd_load     = leave_reset || arm_ok;
  assign cd_val      = arm_ok ? os_val : boot_to_q;

  bfw_tick_gen #(.PRESC(PRESC)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  bfw_countdown #(.CNT_W(CNT_W), .INIT(DEF_TIMEOUT)) u_cd (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_COUNT), .tick(tick),
    .load(cd_load), .load_val(cd_val), .expire(cd_expire)
  );

  bfw_bsp_rotator #(.NPROC(NPROC)) u_rot (
    .clk(clk), .rst_n(rst_n), .advance(boot_expire),
    .bsp_sel(bsp_sel), .fail_mask(fail_mask), .last_fail(last_fail)
  );

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    unique case (st_q)
      ST_COUNT: begin
        if (cd_expire)       st_d = enter_alarm ? ST_ALARM : ST_RESET;
        else if (disarm_cmd) begin st_d = ST_IDLE; mode_d = 1'b0; end
        else if (arm_ok)     mode_d = 1'b1;
      end
      ST_IDLE: begin
        if (arm_ok) begin st_d = ST_COUNT; mode_d = 1'b1; end
      end
      ST_RESET: begin
        if (leave_reset) begin st_d = ST_COUNT; mode_d = 1'b0; end
      end
      default: st_d = ST_ALARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_COUNT;
      mode_q    <= 1'b0;
      boot_to_q <= CNT_W'(DEF_TIMEOUT);
      rc_q      <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      if (load_cmd) boot_to_q <= reg_wdata;
      if (enter_reset)                     rc_q <= RC_W'(RST_CYC - 1);
      else if (st_q == ST_RESET && rc_q != '0) rc_q <= rc_q - RC_W'(1);
    end
  end

  // sticky status, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_boot_fail <= 1'b0;
      sts_os_fail   <= 1'b0;
      sts_all_fail  <= 1'b0;
    end else begin
      if (boot_expire)                     sts_boot_fail <= 1'b1;
      else if (clear_cmd && reg_wdata[0])  sts_boot_fail <= 1'b0;
      if (os_expire)                       sts_os_fail <= 1'b1;
      else if (clear_cmd && reg_wdata[1])  sts_os_fail <= 1'b0;
      if (enter_alarm)                     sts_all_fail <= 1'b1;
      else if (clear_cmd && reg_wdata[2])  sts_all_fail <= 1'b0;
    end
  end

  assign sys_rst_out = (st_q == ST_RESET);
  assign beep_req    = (st_q == ST_ALARM);
  assign wd_running  = (st_q == ST_COUNT);
  assign os_mode     = mode_q;
endmodule

// File: rtl/bfw_checker.sv
`timescale 1ns/1ps
module bfw_checker #(
  parameter int NPROC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             sys_rst_out,
  input logic [NPROC-1:0] bsp_sel,
  input logic [NPROC-1:0] fail_mask,
  input logic             beep_req,
  input logic             wd_running,
  input logic             boot_expire,
  input logic             os_expire,
  input logic             disarm_cmd,
  input logic             cd_expire
);
  AST_BSP_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bsp_sel) == 1); // R4

  AST_MASK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    boot_expire |=> fail_mask == ($past(fail_mask) | $past(bsp_sel))); // R4

  AST_BEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    beep_req |=> beep_req); // R6

  AST_NO_RESET_IN_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    beep_req |-> !sys_rst_out && !wd_running); // R6

  AST_OS_KEEPS_ROTATION: assert property (@(posedge clk) disable iff (!rst_n)
    os_expire |=> $stable(bsp_sel) && $stable(fail_mask) && sys_rst_out); // R9

  AST_DISARM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_cmd && wd_running && !cd_expire |=> !wd_running); // R3

  AST_SOFT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !boot_expire |=> $stable(fail_mask) && $stable(bsp_sel)); // R7
endmodule

bind boot_failover_wdog bfw_checker #(.NPROC(NPROC)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sys_rst_out(sys_rst_out),
  .bsp_sel(bsp_sel), .fail_mask(fail_mask), .beep_req(beep_req),
  .wd_running(wd_running), .boot_expire(boot_expire), .os_expire(os_expire),
  .disarm_cmd(disarm_cmd), .cd_expire(cd_expire)
);

// File: tb/boot_failover_wdog_tb.sv
`timescale 1ns/1ps
module boot_failover_wdog_tb;
  localparam int NP = 3, CW = 21, PR = 4, TPM = 3, DT = 10, RC = 4;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic sys_rst_out, beep_req, wd_running, os_mode;
  logic sts_boot_fail, sts_os_fail, sts_all_fail;
  logic [NP-1:0] bsp_sel, fail_mask;
  int total = 0, bad = 0;
  bit done = 0;

  boot_failover_wdog #(.NPROC(NP), .CNT_W(CW), .PRESC(PR), .TICKS_PER_MIN(TPM),
                       .DEF_TIMEOUT(DT), .RST_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sys_rst_out(sys_rst_out),
    .bsp_sel(bsp_sel), .fail_mask(fail_mask), .beep_req(beep_req),
    .wd_running(wd_running), .os_mode(os_mode), .sts_boot_fail(sts_boot_fail),
    .sts_os_fail(sts_os_fail), .sts_all_fail(sts_all_fail));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = CW'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!sys_rst_out && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (sys_rst_out && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic chk_window(input string req, input int n, input int ticks);
    chk(n >= (ticks - 1) * PR && n <= ticks * PR + 3, req, n, ticks * PR);
  endtask

  // idle for a window, counting reset rises
  task automatic quiet(input string req, input int cycles);
    int rises = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (sys_rst_out) rises++;
    end
    chk(rises == 0, req, rises, 0);
  endtask

  initial begin
    int n, m;
    // R1: reset values
    repeat (2) @(negedge clk);
    chk(bsp_sel == 3'b001 && fail_mask == 0 && !sys_rst_out && !beep_req, "R1 held", bsp_sel, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wd_running && !os_mode && !sts_boot_fail && !sts_os_fail && !sts_all_fail,
        "R1 after release", {wd_running, os_mode, sts_boot_fail, sts_os_fail, sts_all_fail}, 5'b10000);

    // Sweep: processors 0..k-1 fail, processor k disarms (alarm when k==NP)
    for (int k = 0; k <= NP; k++) begin
      do_reset();
      @(negedge clk);
      chk(bsp_sel == 3'b001 && fail_mask == 0 && !beep_req, "R10 restart", {bsp_sel, fail_mask}, 6'b001000);
      for (int i = 0; i < k; i++) begin
        if (i == NP - 1) begin
          n = 0;
          while (!beep_req && n < 4000) begin @(negedge clk); n++; end
          chk_window("R6 alarm timing", n + ((i == 0) ? 1 : 0), DT);
          chk(beep_req && !sys_rst_out && !wd_running && sts_all_fail, "R6 alarm outputs",
              {beep_req, sys_rst_out, wd_running, sts_all_fail}, 4'b1001);
          chk(fail_mask == 3'b111, "R6 mask full", fail_mask, 7);
          quiet("R6 no more resets", 3 * DT * PR);
          chk(beep_req, "R6 beep held", beep_req, 1);
        end else begin
          wait_rise(n);
          chk_window(i == 0 ? "R2 first expiry" : "R5 repeat expiry", n + ((i == 0) ? 1 : 0), DT);
          chk(fail_mask == NP'((1 << (i + 1)) - 1) && sts_boot_fail, "R4 mask/status at expiry",
              fail_mask, (1 << (i + 1)) - 1);
          wait_fall(m);
          chk(m == RC, "R4 pulse length", m, RC);
          chk(bsp_sel == NP'(1 << (i + 1)), "R4 rotated select", bsp_sel, 1 << (i + 1));
          chk(wd_running, "R5 countdown restarted", wd_running, 1);
        end
      end
      if (k < NP) begin
        wr(2'd1, 0);
        chk(!wd_running, "R3 disarm", wd_running, 0);
        quiet("R3 no reset after disarm", 3 * DT * PR);
        chk(bsp_sel == NP'(1 << k) && fail_mask == NP'((1 << k) - 1), "R3 rotation held",
            {bsp_sel, fail_mask}, {NP'(1 << k), NP'((1 << k) - 1)});
        if (k == 1) begin
          chk(sts_boot_fail, "R11 sticky over reset", sts_boot_fail, 1);
          wr(2'd3, 1);
          chk(!sts_boot_fail && fail_mask == 3'b001, "R11 clear leaves mask",
              {sts_boot_fail, fail_mask}, 4'b0001);
        end
      end
    end

    // R10 from alarm
    do_reset();
    @(negedge clk);
    chk(!beep_req && bsp_sel == 3'b001 && fail_mask == 0 && !sts_all_fail, "R10 out of alarm",
        {beep_req, bsp_sel, fail_mask}, 7'b0001000);

    // R8: new load takes effect at the next countdown
    do_reset();
    wr(2'd0, 6);
    wait_rise(n);
    wait_fall(m);
    wait_rise(n);
    chk_window("R8 loaded timeout", n, 6);
    wait_fall(m);
    wr(2'd1, 0);

    // R7: soft reset held through a countdown
    do_reset();
    soft_rst = 1'b1;
    wait_rise(n);
    chk_window("R7 timing under soft reset", n, DT);
    wait_fall(m);
    chk(bsp_sel == 3'b010 && fail_mask == 3'b001, "R7 rotation", {bsp_sel, fail_mask}, 6'b010001);
    wr(2'd1, 0);
    for (int c = 0; c < 20; c++) begin @(negedge clk); soft_rst = ~soft_rst; end
    soft_rst = 1'b0;
    @(negedge clk);
    chk(!wd_running && bsp_sel == 3'b010 && fail_mask == 3'b001, "R7 idle untouched",
        {wd_running, bsp_sel, fail_mask}, 7'b0010001);

    // R9: OS-load timeout sweep over all codes
    do_reset();
    wr(2'd1, 0);
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, s);
      chk(os_mode && wd_running, "R9 armed", {os_mode, wd_running}, 3);
      wait_rise(n);
      chk_window("R9 OS timeout", n, (s + 1) * 5 * TPM);
      chk(bsp_sel == 3'b001 && fail_mask == 0 && sts_os_fail && !sts_boot_fail,
          "R9 rotation untouched", {bsp_sel, fail_mask, sts_os_fail, sts_boot_fail}, 8'b00100010);
      wait_fall(m);
      chk(m == RC, "R9 pulse length", m, RC);
      chk(!os_mode && wd_running, "R9 back to start-up mode", {os_mode, wd_running}, 1);
      wr(2'd3, 2);
      chk(!sts_os_fail, "R11 clear os flag", sts_os_fail, 0);
      wr(2'd1, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule